// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a group of external input lines and turns chosen signal transitions on them into interrupt and event requests for a bus-clocked system. Each line can react to a rising transition, a falling transition or both. An interrupt mask for each line decides whether a detected transition is recorded in a pending register. An event mask for each line decides whether the transition also produces a single-cycle event pulse.

A line may carry a pulse narrower than one bus clock period. Each line therefore has an asynchronous capture stage: two toggle flops, clocked by the line itself, one on each polarity. Their state crosses into the bus clock domain through a two-flop synchronizer before the change is detected. Software acknowledges a request by writing ones to a clear port. It can also raise a request without any line activity through a software trigger write. Routing of port pins onto the lines is done outside this block.

Top module: `edge_irq_ctrl`

## Requirements
- R1: The block has NUM_LINES independent lines (default 18). Line k uses bit k of every per-line port, and transitions on several lines in the same cycle are all recorded.
- R2: A rising transition on line k with rise_en[k]=1 and irq_mask[k]=1 sets pend_o[k]. The bit becomes visible after the third rising clk edge that follows the transition.
- R3: A falling transition on line k with fall_en[k]=1 sets pend_o[k] with the same latency. With both enables set, either polarity sets it.
- R4: A transition whose polarity enable is 0 leaves pend_o and evt_o unchanged.
- R5: With irq_mask[k]=0, no transition and no software trigger on line k sets pend_o[k].
- R6: A high pulse on a line that is narrower than one clk period is detected when either polarity is enabled.
- R7: irq_req_o is 1 exactly when at least one pend_o bit is 1.
- R8: evt_o[k] pulses high for one cycle, in the cycle pend_o[k] would be set, when a transition is detected and evt_mask[k]=1, whatever the value of irq_mask[k].
- R9: With clr_wr=1, every line whose bit is 1 in clr_bits has its pending bit cleared at the next clk edge. A 0 bit in clr_bits leaves its pending bit unchanged.
- R10: If a pending bit is set and cleared in the same cycle, the set wins and the bit reads 1.
- R11: With sw_trig_wr=1, each line whose bit is 1 in sw_trig_bits behaves as if a transition were detected at the next clk edge: its pending bit is set if irq_mask is 1, and its event pulses if evt_mask is 1.
- R12: While rst_n=0 (synchronous), pend_o, evt_o and irq_req_o are 0. Line levels held across reset produce no detection after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES | External input lines, asynchronous to clk |
| rise_en | input | NUM_LINES | Rising-transition enable for each line |
| fall_en | input | NUM_LINES | Falling-transition enable for each line |
| irq_mask | input | NUM_LINES | 1 lets a detection set the pending bit |
| evt_mask | input | NUM_LINES | 1 lets a detection pulse the event output |
| sw_trig_wr | input | 1 | Software trigger write strobe |
| sw_trig_bits | input | NUM_LINES | Lines to trigger by software |
| clr_wr | input | 1 | Pending clear write strobe |
| clr_bits | input | NUM_LINES | Lines whose pending bit is cleared (1 clears) |
| pend_o | output | NUM_LINES | Pending register |
| irq_req_o | output | 1 | OR of all pending bits |
| evt_o | output | NUM_LINES | One-cycle event pulses |

## Verification
The bench builds the block with its defaults: 18 lines and a two-stage synchronizer. The top line index 17 and an all-lines-at-once transition are exercised at full width. The two-stage depth fixes a latency of three clk edges between a transition on a line and its result. The bench samples at exactly that cycle, so an extra or a missing synchronizer stage shows up as a wrong value. A 1 ns pulse on an 8 ns clock exercises the capture path for pulses narrower than one period.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the edge interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package eirq_pkg;
    localparam int unsigned EIRQ_LINES_DEFAULT = 18;
    localparam int unsigned EIRQ_SYNC_DEFAULT  = 2;

    // Per-line detection result in the bus clock domain, one cycle wide.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_det_t;
endpackage

// File: rtl/eirq_edge_capture.sv
`timescale 1ns/1ps
// Asynchronous edge capture for one line.
// A toggle flop clocked by the line flips on each rising transition, and a
// second one flips on each falling transition, so a pulse of any width
// leaves a lasting mark. The toggle states are carried through SYNC_STAGES
// bus-clock flops, and a change seen at the end of the chain is reported
// as a one-cycle detection.
// Assumes: at most one transition of each polarity per bus clock period is
// counted. The toggle flops need no reset, because the chain is loaded with
// their value during reset.
module eirq_edge_capture
    import eirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = EIRQ_SYNC_DEFAULT
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    output edge_det_t det
);
    localparam int unsigned LAST = SYNC_STAGES;

    logic       rise_tog;
    logic       fall_tog;
    logic [1:0] tog;
    logic [1:0] chain [LAST+1];
    logic [1:0] diff;

    // Flip on every rising transition of the line.
    always_ff @(posedge pin) rise_tog <= ~rise_tog;

    // Flip on every falling transition of the line.
    always_ff @(negedge pin) fall_tog <= ~fall_tog;

    assign tog = {rise_tog, fall_tog};

    // Synchronizer plus history stage. Reset aligns every stage to the toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= int'(LAST); i++) chain[i] <= tog;
        end else begin
            chain[0] <= tog;
            for (int i = 1; i <= int'(LAST); i++) chain[i] <= chain[i-1];
        end
    end

    // A toggle change leaving the synchronizer marks one transition.
    assign diff     = chain[LAST-1] ^ chain[LAST];
    assign det.rise = diff[1];
    assign det.fall = diff[0];

    // R12
    no_det_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (det == '0));
endmodule

// File: rtl/eirq_pending.sv
`timescale 1ns/1ps
// Pending register with write-one-to-clear.
// A set request wins over a clear request for the same bit in the same
// cycle, so a new request is never lost.
// Assumes: set_i and clr_i are single-cycle requests in the clk domain.
module eirq_pending #(
    parameter int unsigned NUM_LINES = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o
);
    // Hold, clear or set each pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
        // R9
        clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
        // R9
        hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[k] && !clr_i[k]) |=> pend_o[k]);
        // R10
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> pend_o[k]);
        // R12
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> !pend_o[k]);
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
// Edge-triggered external interrupt controller (top).
// One capture unit per line, a shared pending register and registered
// event pulses. Polarity enables, masks and the software trigger are
// applied in the clk domain after synchronization.
// Assumes: all control inputs are synchronous to clk. line_in is
// asynchronous.
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_LINES   = EIRQ_LINES_DEFAULT,
    parameter int unsigned SYNC_STAGES = EIRQ_SYNC_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] rise_en,
    input  logic [NUM_LINES-1:0] fall_en,
    input  logic [NUM_LINES-1:0] irq_mask,
    input  logic [NUM_LINES-1:0] evt_mask,
    input  logic                 sw_trig_wr,
    input  logic [NUM_LINES-1:0] sw_trig_bits,
    input  logic                 clr_wr,
    input  logic [NUM_LINES-1:0] clr_bits,
    output logic [NUM_LINES-1:0] pend_o,
    output logic                 irq_req_o,
    output logic [NUM_LINES-1:0] evt_o
);
    edge_det_t            det [NUM_LINES];
    logic [NUM_LINES-1:0] edge_hit;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] pend_set;
    logic [NUM_LINES-1:0] pend_clr;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        eirq_edge_capture #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (line_in[k]),
            .det  (det[k])
        );

        // Keep only the transitions whose polarity is enabled.
        assign edge_hit[k] = (det[k].rise & rise_en[k]) | (det[k].fall & fall_en[k]);
    end

    // Merge line detections with the software trigger.
    assign hit      = edge_hit | (sw_trig_bits & {NUM_LINES{sw_trig_wr}});
    assign pend_set = hit & irq_mask;
    assign pend_clr = clr_bits & {NUM_LINES{clr_wr}};

    eirq_pending #(
        .NUM_LINES(NUM_LINES)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (pend_set),
        .clr_i (pend_clr),
        .pend_o(pend_o)
    );

    // Register event pulses so they line up with the pending update.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_o <= '0;
        else        evt_o <= hit & evt_mask;
    end

    // Any pending line requests service.
    assign irq_req_o = |pend_o;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
        // R8
        evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[k] |-> $past(evt_mask[k]));
        // R5
        pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[k]) |-> $past(irq_mask[k]));
    end
endmodule

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of single-line transitions, then
// directed tests for reset, clearing, software trigger and width.
module tb_edge_irq_ctrl;
    localparam int NL = 18;
    localparam logic [1:0] ACT_RISE  = 2'd0;
    localparam logic [1:0] ACT_FALL  = 2'd1;
    localparam logic [1:0] ACT_PULSE = 2'd2;

    typedef struct packed {
        logic [4:0] line;
        logic [1:0] act;
        logic       r, f, im, em;
        logic       xp, xe;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  ACT_RISE,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 R8
        '{5'd1,  ACT_FALL,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
        '{5'd2,  ACT_RISE,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{5'd3,  ACT_FALL,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
        '{5'd4,  ACT_RISE,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R3
        '{5'd5,  ACT_FALL,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
        '{5'd6,  ACT_RISE,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 R8
        '{5'd7,  ACT_PULSE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R6
        '{5'd8,  ACT_PULSE, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R6
        '{5'd17, ACT_PULSE, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R1 R6
        '{5'd9,  ACT_RISE,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R5
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] line_in, rise_en, fall_en, irq_mask, evt_mask;
    logic          sw_trig_wr, clr_wr;
    logic [NL-1:0] sw_trig_bits, clr_bits;
    logic [NL-1:0] pend_o, evt_o;
    logic          irq_req_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    edge_irq_ctrl #(.NUM_LINES(NL), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .rise_en(rise_en),
        .fall_en(fall_en), .irq_mask(irq_mask), .evt_mask(evt_mask),
        .sw_trig_wr(sw_trig_wr), .sw_trig_bits(sw_trig_bits),
        .clr_wr(clr_wr), .clr_bits(clr_bits), .pend_o(pend_o),
        .irq_req_o(irq_req_o), .evt_o(evt_o)
    );

    task automatic check(input string req, input logic [NL-1:0] act,
                         input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_bits = '1; clr_wr = 1'b1;
        cyc();
        clr_wr = 1'b0; clr_bits = '0;
    endtask

    task automatic run_vec(input vec_t v);
        int li;
        logic [NL-1:0] one;
        li  = int'(v.line);
        one = '0;
        one[li] = 1'b1;
        rise_en = '0; fall_en = '0; irq_mask = '0; evt_mask = '0;
        line_in = '0;
        if (v.act == ACT_FALL) line_in[li] = 1'b1;
        repeat (5) cyc();
        clear_all();
        rise_en[li] = v.r; fall_en[li] = v.f;
        irq_mask[li] = v.im; evt_mask[li] = v.em;
        cyc();
        case (v.act)
            ACT_RISE: line_in[li] = 1'b1;
            ACT_FALL: line_in[li] = 1'b0;
            default: begin
                line_in[li] = 1'b1;
                #1 line_in[li] = 1'b0;
            end
        endcase
        repeat (3) cyc();
        check($sformatf("R2/R3/R4/R5/R6 vec line %0d pend", li), pend_o, v.xp ? one : '0);
        check($sformatf("R8 vec line %0d evt", li), evt_o, v.xe ? one : '0);
        check($sformatf("R7 vec line %0d irq", li), NL'(irq_req_o), NL'(v.xp));
        cyc();
        check($sformatf("R8 vec line %0d evt one cycle", li), evt_o, '0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: cycles %0d expected fewer than %0d", 100000, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        line_in = '0; line_in[10] = 1'b1;
        rise_en = '1; fall_en = '1; irq_mask = '1; evt_mask = '1;
        sw_trig_wr = 1'b0; sw_trig_bits = '0; clr_wr = 1'b0; clr_bits = '0;
        repeat (5) cyc();
        // R12 outputs held low in reset
        check("R12 reset pend", pend_o, '0);
        check("R12 reset evt", evt_o, '0);
        check("R12 reset irq", NL'(irq_req_o), '0);
        rst_n = 1'b1;
        repeat (6) cyc();
        // R12 a level held across reset is not a transition
        check("R12 no detection after reset", pend_o, '0);
        check("R12 no event after reset", evt_o, '0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1 all lines rise in the same cycle
        rise_en = '1; fall_en = '0; irq_mask = '1; evt_mask = '0;
        line_in = '0;
        repeat (5) cyc();
        clear_all();
        line_in = '1;
        repeat (3) cyc();
        check("R1 all lines pending", pend_o, '1);

        // R11 software trigger, irq mask all on, event mask only line 3
        rise_en = '0; fall_en = '0; evt_mask = '0; evt_mask[3] = 1'b1;
        clear_all();
        sw_trig_bits = '0; sw_trig_bits[3] = 1'b1; sw_trig_bits[4] = 1'b1;
        sw_trig_wr = 1'b1;
        cyc();
        sw_trig_wr = 1'b0; sw_trig_bits = '0;
        check("R11 sw trigger pend", pend_o, NL'(18'h00018));
        check("R11 sw trigger evt", evt_o, NL'(18'h00008));
        cyc();
        check("R11 sw trigger evt one cycle", evt_o, '0);

        // R9 writing zeros changes nothing
        clr_bits = '0; clr_wr = 1'b1;
        cyc();
        clr_wr = 1'b0;
        check("R9 zero write holds", pend_o, NL'(18'h00018));
        // R9 clear line 3 only
        clr_bits = '0; clr_bits[3] = 1'b1; clr_wr = 1'b1;
        cyc();
        clr_wr = 1'b0; clr_bits = '0;
        check("R9 clear one bit", pend_o, NL'(18'h00010));
        check("R7 irq with one pending", NL'(irq_req_o), NL'(1));
        clr_bits = '0; clr_bits[4] = 1'b1; clr_wr = 1'b1;
        cyc();
        clr_wr = 1'b0; clr_bits = '0;
        check("R7 irq low when none pending", NL'(irq_req_o), '0);

        // R5 software trigger on a masked line
        irq_mask = '1; irq_mask[2] = 1'b0;
        sw_trig_bits = '0; sw_trig_bits[2] = 1'b1; sw_trig_wr = 1'b1;
        cyc();
        sw_trig_wr = 1'b0; sw_trig_bits = '0;
        check("R5 masked sw trigger", pend_o, '0);

        // R10 set and clear in the same cycle
        irq_mask = '1;
        sw_trig_bits = '0; sw_trig_bits[6] = 1'b1; sw_trig_wr = 1'b1;
        clr_bits = '0; clr_bits[6] = 1'b1; clr_wr = 1'b1;
        cyc();
        sw_trig_wr = 1'b0; sw_trig_bits = '0; clr_wr = 1'b0; clr_bits = '0;
        check("R10 set wins over clear", pend_o, NL'(18'h00040));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule